// File: doc/BRIEF.md
# Dual Maskable Calendar Alarm

This block keeps two alarm settings beside a running calendar and tests each one against the live time once per second. Each setting has six fields: seconds, minutes, hours, weekday, day of month and month. Every field has its own match enable, so an alarm can fire once a day, once an hour, on one weekday, or on any mix of these. When an alarm hits, it raises a sticky status flag that the host polls and clears. The flag can also pull a shared active-low pin low.

Each alarm has a repeat control. With repeat off, an alarm is a single event: it disarms itself when it fires. With repeat on, it stays armed and fires again each time its enabled fields match. The output pin is shared with a frequency output. A two-bit select chooses between the interrupt and one of three externally generated square waves.

The host programs each alarm through a small write port that carries an alarm index, an address and a data byte. Clear strobes, one per alarm, reset the flags.

Top module: `cal_alarm_pair`

## Requirements
- R1: After reset, both flags are 0, every field enable and every arm and repeat and interrupt-enable bit is 0, and the pin is high while the output select is 0. A tick with any live time raises no flag.
- R2: The live time bus carries six 7-bit BCD fields. Field k sits at bits [7k+6:7k], in the order seconds, minutes, hours, weekday, day, month for k = 0..5. A write with addr k (0..5) sets that field's compare value from data bits [6:0] and its enable from data bit 7.
- R3: A write with addr 6 sets the control bits: bit 0 arms the alarm, bit 1 selects repeat, and bit 2 lets the flag drive the pin. The alarm index is wr_sel (0 or 1).
- R4: When an armed alarm sees a tick and every enabled field equals the live field, its flag is 1 from the clock edge that samples the tick onward. Fields whose enable is 0 are ignored.
- R5: An alarm with no field enabled never fires.
- R6: Without a tick, no compare takes place, so a match that lasts many cycles raises the flag only on a tick.
- R7: With repeat off, firing clears the arm bit, so later matching ticks raise no flag until the host re-arms the alarm.
- R8: With repeat on, the alarm stays armed and fires again on every later matching tick.
- R9: A flag stays set until its clear strobe. A clear makes the flag 0 on the next edge. If a fire and a clear fall on the same edge, the fire wins.
- R10: With the output select at 0, the pin is low exactly when some flag is set whose interrupt-enable bit is 1.
- R11: With the output select at 1, 2 or 3, the pin follows freq_in bit 0, 1 or 2 respectively, whatever the flags are.
- R12: The two alarms are independent. Writes, ticks and clears aimed at one alarm leave the other's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| now_time | input | 42 | Live BCD fields, 7 bits each, seconds in the lowest field |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Alarm index for the write |
| wr_addr | input | 3 | 0..5 field, 6 control |
| wr_data | input | 8 | Write data |
| clr_flag | input | 2 | Per-alarm flag clear strobes |
| fo_sel | input | 2 | Pin source: 0 interrupt, 1..3 frequency input |
| freq_in | input | 3 | Pre-divided square waves |
| alm_flag | output | 2 | Sticky alarm status flags |
| alm_pin | output | 1 | Shared interrupt (active low) or frequency pin |

## Verification
A fire and a host clear can land on the same clock edge. The bench provokes this by driving the clear strobe in the same cycle as a matching tick on a repeating alarm. It then judges that the flag is still set after that edge and drops only after a later clear on its own. A second collision is a fire on one alarm in the same cycle as a clear of the other. The bench checks that each flag follows only its own inputs.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned N_FIELDS    = 6;
  localparam int unsigned VAL_W       = 7;
  localparam int unsigned WDATA_W     = 8;
  localparam int unsigned WADDR_W     = 3;
  localparam int unsigned TIME_W      = N_FIELDS * VAL_W;
  localparam int unsigned CTL_ADDR    = 6;
  localparam int unsigned EN_BIT      = WDATA_W - 1;
  localparam int unsigned CTL_ARM_BIT = 0;
  localparam int unsigned CTL_RPT_BIT = 1;
  localparam int unsigned CTL_IE_BIT  = 2;

  typedef enum logic [1:0] {
    FO_IRQ  = 2'd0,
    FO_SLOW = 2'd1,
    FO_MID  = 2'd2,
    FO_FAST = 2'd3
  } fo_mode_e;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
(
  input  logic [N_FIELDS-1:0][VAL_W-1:0] set_val,
  input  logic [N_FIELDS-1:0]            set_en,
  input  logic [TIME_W-1:0]              now_time,
  output logic                           hit
);
  logic [N_FIELDS-1:0] field_ok;

  for (genvar k = 0; k < N_FIELDS; k++) begin : g_field
    assign field_ok[k] = !set_en[k] || (set_val[k] == now_time[k*VAL_W +: VAL_W]);
  end

  assign hit = (|set_en) && (&field_ok);
endmodule

// File: rtl/alarm_slot.sv
module alarm_slot
  import cal_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [TIME_W-1:0]  now_time,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [WDATA_W-1:0] wr_data,
  input  logic               clr,
  output logic               flag,
  output logic               irq_req
);
  logic [N_FIELDS-1:0][VAL_W-1:0] fval_q, fval_d;
  logic [N_FIELDS-1:0]            fen_q, fen_d;
  logic armed_q, armed_d, rpt_q, rpt_d, ie_q, ie_d, flag_q, flag_d;
  logic hit, fire, ctl_wr;

  alarm_match u_match (
    .set_val  (fval_q),
    .set_en   (fen_q),
    .now_time (now_time),
    .hit      (hit)
  );

  assign ctl_wr = wr_en && (wr_addr == WADDR_W'(CTL_ADDR));
  assign fire   = sec_tick && armed_q && hit;

  always_comb begin
    fval_d  = fval_q;
    fen_d   = fen_q;
    armed_d = armed_q;
    rpt_d   = rpt_q;
    ie_d    = ie_q;
    flag_d  = flag_q;
    for (int k = 0; k < N_FIELDS; k++) begin
      if (wr_en && (wr_addr == WADDR_W'(k))) begin
        fval_d[k] = wr_data[VAL_W-1:0];
        fen_d[k]  = wr_data[EN_BIT];
      end
    end
    if (ctl_wr) begin
      armed_d = wr_data[CTL_ARM_BIT];
      rpt_d   = wr_data[CTL_RPT_BIT];
      ie_d    = wr_data[CTL_IE_BIT];
    end
    if (fire) begin
      flag_d = 1'b1;
      if (!rpt_q && !ctl_wr) armed_d = 1'b0;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fval_q  <= '0;
      fen_q   <= '0;
      armed_q <= 1'b0;
      rpt_q   <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      fval_q  <= fval_d;
      fen_q   <= fen_d;
      armed_q <= armed_d;
      rpt_q   <= rpt_d;
      ie_q    <= ie_d;
      flag_q  <= flag_d;
    end
  end

  assign flag    = flag_q;
  assign irq_req = flag_q && ie_q;

  AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(sec_tick)); // R6
  AST_EMPTY_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (|fen_q)); // R5
  AST_ONESHOT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && !$past(rpt_q) && !$past(ctl_wr)) |-> !armed_q); // R7
  AST_REPEAT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire) && $past(rpt_q) && !$past(ctl_wr)) |-> armed_q); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && !$past(fire)) |-> !flag_q); // R9
endmodule

// File: rtl/pin_select.sv
module pin_select
  import cal_alarm_pkg::*;
(
  input  logic [1:0] fo_sel,
  input  logic       irq_any,
  input  logic [2:0] freq_in,
  output logic       pin
);
  always_comb begin
    unique case (fo_mode_e'(fo_sel))
      FO_IRQ:  pin = !irq_any;
      FO_SLOW: pin = freq_in[0];
      FO_MID:  pin = freq_in[1];
      FO_FAST: pin = freq_in[2];
      default: pin = 1'b1;
    endcase
  end
endmodule

// File: rtl/cal_alarm_pair.sv
module cal_alarm_pair
  import cal_alarm_pkg::*;
#(
  parameter  int N_ALM = 2,
  localparam int SEL_W = (N_ALM > 1) ? $clog2(N_ALM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [TIME_W-1:0]  now_time,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [WDATA_W-1:0] wr_data,
  input  logic [N_ALM-1:0]   clr_flag,
  input  logic [1:0]         fo_sel,
  input  logic [2:0]         freq_in,
  output logic [N_ALM-1:0]   alm_flag,
  output logic               alm_pin
);
  logic [N_ALM-1:0] irq_req;

  for (genvar i = 0; i < N_ALM; i++) begin : g_alm
    alarm_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .now_time (now_time),
      .wr_en    (wr_en && (wr_sel == SEL_W'(i))),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .clr      (clr_flag[i]),
      .flag     (alm_flag[i]),
      .irq_req  (irq_req[i])
    );
  end

  pin_select u_pin (
    .fo_sel  (fo_sel),
    .irq_any (|irq_req),
    .freq_in (freq_in),
    .pin     (alm_pin)
  );

  AST_IRQ_LOW_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((fo_sel == 2'd0) && !alm_pin) |-> (|alm_flag)); // R10
endmodule

// File: tb/cal_alarm_pair_tb.sv
module cal_alarm_pair_tb;
  import cal_alarm_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sec_tick;
  logic [TIME_W-1:0] now_time;
  logic              wr_en;
  logic [0:0]        wr_sel;
  logic [2:0]        wr_addr;
  logic [7:0]        wr_data;
  logic [1:0]        clr_flag;
  logic [1:0]        fo_sel;
  logic [2:0]        freq_in;
  logic [1:0]        alm_flag;
  logic              alm_pin;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_alarm_pair u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now_time(now_time),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_flag(clr_flag), .fo_sel(fo_sel), .freq_in(freq_in),
    .alm_flag(alm_flag), .alm_pin(alm_pin)
  );

  // base compare values: sec, min, hour, weekday, day, month
  localparam logic [6:0] BASE [6] = '{7'h45, 7'h30, 7'h12, 7'h03, 7'h21, 7'h07};

  // vector: {enable mask[5:0], differing-field mask[5:0], expected fire}
  localparam logic [12:0] VEC [8] = '{
    {6'b111111, 6'b000000, 1'b1},
    {6'b111111, 6'b000100, 1'b0},
    {6'b000001, 6'b111110, 1'b1},
    {6'b000000, 6'b000000, 1'b0},
    {6'b101000, 6'b010111, 1'b1},
    {6'b011010, 6'b000010, 1'b0},
    {6'b100000, 6'b000000, 1'b1},
    {6'b000110, 6'b001000, 1'b1}
  };

  function automatic logic [TIME_W-1:0] mk_time(input logic [5:0] diff);
    logic [TIME_W-1:0] t;
    for (int k = 0; k < 6; k++) t[k*7 +: 7] = diff[k] ? BASE[k] + 7'd1 : BASE[k];
    return t;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(input logic sel, input logic [5:0] en, input logic [6:0] sec_val);
    for (int k = 0; k < 6; k++)
      wr(sel, 3'(k), {en[k], (k == 0) ? sec_val : BASE[k]});
  endtask

  task automatic tick(input logic [1:0] clr);
    @(negedge clk);
    sec_tick = 1'b1; clr_flag = clr;
    @(negedge clk);
    sec_tick = 1'b0; clr_flag = 2'b00;
  endtask

  task automatic clear(input logic [1:0] c);
    @(negedge clk);
    clr_flag = c;
    @(negedge clk);
    clr_flag = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; now_time = '0; wr_en = 1'b0; wr_sel = '0;
    wr_addr = '0; wr_data = '0; clr_flag = '0; fo_sel = 2'd0; freq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flag0", alm_flag[0], 1'b0);
    chk("R1 flag1", alm_flag[1], 1'b0);
    chk("R1 pin", alm_pin, 1'b1);
    tick(2'b00);
    chk("R1 no fire after reset", |alm_flag, 1'b0);

    // table walk: alarm 0 in repeat mode with pin enabled (R2 R3 R4 R5)
    for (int v = 0; v < 8; v++) begin
      prog(1'b0, VEC[v][12:7], BASE[0]);
      wr(1'b0, 3'd6, 8'b0000_0111);
      now_time = mk_time(VEC[v][6:1]);
      tick(2'b00);
      chk($sformatf("R4 vec%0d flag", v), alm_flag[0], VEC[v][0]);
      chk($sformatf("R10 vec%0d pin", v), alm_pin, !VEC[v][0]);
      clear(2'b01);
    end

    // R6 no compare without tick
    prog(1'b0, 6'b111111, BASE[0]);
    wr(1'b0, 3'd6, 8'b0000_0111);
    now_time = mk_time(6'b0);
    repeat (5) @(negedge clk);
    chk("R6 held match no tick", alm_flag[0], 1'b0);
    tick(2'b00);
    chk("R6 fires on tick", alm_flag[0], 1'b1);
    // R9 sticky
    repeat (4) @(negedge clk);
    chk("R9 sticky", alm_flag[0], 1'b1);
    clear(2'b01);
    chk("R9 clear", alm_flag[0], 1'b0);
    // R9 fire and clear on the same edge: fire wins
    tick(2'b01);
    chk("R9 fire beats clear", alm_flag[0], 1'b1);
    clear(2'b01);
    chk("R9 later clear", alm_flag[0], 1'b0);
    // R8 repeat fires again
    tick(2'b00);
    chk("R8 repeat fires", alm_flag[0], 1'b1);
    clear(2'b01);
    tick(2'b00);
    chk("R8 repeat fires again", alm_flag[0], 1'b1);
    clear(2'b01);

    // R7 one-shot
    wr(1'b0, 3'd6, 8'b0000_0101);
    tick(2'b00);
    chk("R7 first fire", alm_flag[0], 1'b1);
    clear(2'b01);
    tick(2'b00);
    chk("R7 disarmed", alm_flag[0], 1'b0);

    // R10 interrupt enable gates the pin
    wr(1'b0, 3'd6, 8'b0000_0011);
    tick(2'b00);
    chk("R10 flag without ie", alm_flag[0], 1'b1);
    chk("R10 pin high without ie", alm_pin, 1'b1);
    wr(1'b0, 3'd6, 8'b0000_0111);
    chk("R10 pin low with ie", alm_pin, 1'b0);
    clear(2'b01);
    chk("R10 pin released", alm_pin, 1'b1);

    // R12 independence: alarm 1 matches a different second
    prog(1'b1, 6'b111111, 7'h10);
    wr(1'b1, 3'd6, 8'b0000_0111);
    chk("R12 alarm1 writes left flag0", alm_flag[0], 1'b0);
    now_time = mk_time(6'b0);
    tick(2'b00);
    chk("R12 flag0 fires", alm_flag[0], 1'b1);
    chk("R12 flag1 quiet", alm_flag[1], 1'b0);
    now_time[6:0] = 7'h10;
    tick(2'b01);
    chk("R12 flag1 fires", alm_flag[1], 1'b1);
    chk("R12 flag0 cleared", alm_flag[0], 1'b0);
    clear(2'b01);
    chk("R12 clr0 keeps flag1", alm_flag[1], 1'b1);
    chk("R10 pin from alarm1", alm_pin, 1'b0);

    // R11 frequency modes ignore flags
    fo_sel = 2'd1; freq_in = 3'b001; #1;
    chk("R11 sel1 high", alm_pin, 1'b1);
    freq_in = 3'b110; #1;
    chk("R11 sel1 low", alm_pin, 1'b0);
    fo_sel = 2'd2; freq_in = 3'b010; #1;
    chk("R11 sel2", alm_pin, 1'b1);
    fo_sel = 2'd3; freq_in = 3'b011; #1;
    chk("R11 sel3 low", alm_pin, 1'b0);
    freq_in = 3'b100; #1;
    chk("R11 sel3 high", alm_pin, 1'b1);
    fo_sel = 2'd0; #1;
    chk("R10 back to irq", alm_pin, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule